// File: doc/BRIEF.md
# Genetic Search Sequencer

This block runs a genetic search over a small population of bit-string individuals held in on-chip registers. After a start pulse it loads its 32-bit pseudo-random generator from a seed input and fills the population with random genes. Then it loops over generations. In each generation it hands every individual in turn to an external fitness evaluator through a request/acknowledge handshake, and it records the best individual seen. It then breeds the next population and repeats.

Breeding works as follows:
- The best individual so far is carried unchanged into slot 0 of the next generation.
- Every other slot receives a child. Its two parents are drawn by fitness-proportional (roulette) selection.
- The child takes each bit from one parent or the other under a random mask.
- The child is then mutated bit by bit against a programmable threshold.

The run ends when the generation limit is reached, or when the best fitness has not improved for a set number of generations.

The state machine has these states, each named by what it does:
- `ST_IDLE`: wait for start.
- `ST_SEED`: write random genes.
- `ST_EVAL`: fitness handshake.
- `ST_JUDGE`: update the generation and stall counters, decide stop or breed, and write the elite.
- `ST_PICK_A` / `ST_PICK_B`: draw a roulette target.
- `ST_WALK_A` / `ST_WALK_B`: walk a running sum to find a parent.
- `ST_CROSS`: masked crossover.
- `ST_MUTATE`: one bit per cycle.
- `ST_STORE`: write the child.
- `ST_COMMIT`: swap in the new population.
- `ST_DONE`: finished.

The transitions are:
- IDLE→SEED and DONE→SEED on start.
- SEED→EVAL after the last slot.
- EVAL→JUDGE after the last acknowledge.
- JUDGE→DONE on a stop condition, otherwise JUDGE→PICK_A.
- PICK_A→WALK_A→PICK_B→WALK_B→CROSS→MUTATE→STORE.
- STORE→PICK_A for the next child, or STORE→COMMIT after the last one.
- COMMIT→EVAL.

Top module: `ga_engine`

## Requirements
- R1: While reset is applied, and after it is released, `done` and `fit_req` are 0, `gen_count` is 0 and `best_fit` is 0.
- R2: A start pulse, accepted in idle or done, loads the generator from `seed`. A zero seed is replaced by a fixed nonzero value. The first population therefore consists of varied, not identical, individuals even for seed 0.
- R3: Each generation issues exactly POP fitness requests, one per slot in slot order. `fit_req` stays high with `fit_ind` stable until `fit_ack` is seen.
- R4: The first individual evaluated after start becomes the best. A later one replaces it only when its fitness is strictly greater. `best_fit` and `best_ind` report the best fitness and individual.
- R5: From the second generation on, the first individual presented in each generation equals the best individual found so far.
- R6: Parents are drawn with probability proportional to fitness, and a zero-fitness individual is never drawn while the total is nonzero. When the whole generation has zero fitness, slot 0 is drawn.
- R7: Every child bit comes from one of its two parents, chosen per bit by a random mask.
- R8: A child bit is flipped when the low byte of the generator is below `mut_thresh`. A threshold of 0 means no mutation.
- R9: The run stops after MAX_GEN evaluated generations, and `gen_count` then equals MAX_GEN.
- R10: A stall counter is cleared by any generation that improves the best and incremented otherwise. The run stops when the counter reaches STALL_LIM.
- R11: Once stopped, `done` stays high and `fit_req` stays low until the next start. `gen_count` holds the number of evaluated generations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (accepted in idle or done) |
| seed | input | 32 | Generator seed |
| mut_thresh | input | 8 | Per-bit mutation threshold |
| fit_req | output | 1 | Fitness request valid |
| fit_ind | output | GENE_W | Individual to evaluate |
| fit_ack | input | 1 | Evaluator accepts and returns `fit_val` |
| fit_val | input | FIT_W | Fitness of `fit_ind` |
| done | output | 1 | Run finished |
| gen_count | output | GEN_W | Generations evaluated |
| best_fit | output | FIT_W | Best fitness found |
| best_ind | output | GENE_W | Best individual found |

## Verification
Each fitness value is taken on the rising edge where `fit_ack` meets `fit_req`. `best_fit` and `best_ind` therefore reflect that value one edge later. `done` rises one edge after the last acknowledge of the final generation, because JUDGE sits between them. The bench drives `fit_ack` at the falling edge on which it observes `fit_req`. It keeps its own model of best, stall and generation count from the values it returned, and it compares the final outputs only once `done` is seen at a falling edge. Individuals are compared as they appear on `fit_ind`, generation by generation, so every check sees a value that has already settled.

// File: rtl/ga_pkg.sv
package ga_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SEED,
        ST_EVAL,
        ST_JUDGE,
        ST_PICK_A,
        ST_WALK_A,
        ST_PICK_B,
        ST_WALK_B,
        ST_CROSS,
        ST_MUTATE,
        ST_STORE,
        ST_COMMIT,
        ST_DONE
    } ga_state_e;

    localparam logic [31:0] LFSR_TAPS     = 32'h8020_0003;
    localparam logic [31:0] LFSR_FALLBACK = 32'hACE1_2468;
endpackage

// File: rtl/ga_lfsr.sv
module ga_lfsr
    import ga_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [31:0] seed,
    output logic [31:0] q
);
    // Galois form, right shift, maximal length
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= LFSR_FALLBACK;
        else if (load)
            q <= (seed == 32'h0) ? LFSR_FALLBACK : seed;
        else
            q <= {1'b0, q[31:1]} ^ (q[0] ? LFSR_TAPS : 32'h0);
    end
endmodule

// File: rtl/ga_pop_store.sv
module ga_pop_store #(
    parameter int POP    = 10,
    parameter int GENE_W = 16,
    parameter int FIT_W  = 16,
    localparam int IDX_W = (POP > 1) ? $clog2(POP) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seed_we,
    input  logic [IDX_W-1:0]  seed_idx,
    input  logic [GENE_W-1:0] seed_gene,
    input  logic              fit_we,
    input  logic [IDX_W-1:0]  fit_idx,
    input  logic [FIT_W-1:0]  fit_in,
    input  logic              nxt_we,
    input  logic [IDX_W-1:0]  nxt_idx,
    input  logic [GENE_W-1:0] nxt_gene,
    input  logic              commit,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [GENE_W-1:0] rd_gene,
    output logic [FIT_W-1:0]  rd_fit
);
    logic [GENE_W-1:0] cur [POP];
    logic [GENE_W-1:0] nxt [POP];
    logic [FIT_W-1:0]  fit [POP];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < POP; i++) begin
                cur[i] <= '0;
                nxt[i] <= '0;
                fit[i] <= '0;
            end
        end else begin
            for (int i = 0; i < POP; i++) begin
                if (commit)
                    cur[i] <= nxt[i];
                else if (seed_we && seed_idx == IDX_W'(i))
                    cur[i] <= seed_gene;
                if (nxt_we && nxt_idx == IDX_W'(i))
                    nxt[i] <= nxt_gene;
                if (fit_we && fit_idx == IDX_W'(i))
                    fit[i] <= fit_in;
            end
        end
    end

    always_comb begin
        rd_gene = '0;
        rd_fit  = '0;
        for (int i = 0; i < POP; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_gene = cur[i];
                rd_fit  = fit[i];
            end
        end
    end
endmodule

// File: rtl/ga_gene_ops.sv
module ga_gene_ops #(
    parameter int GENE_W = 16,
    localparam int BIT_W = (GENE_W > 1) ? $clog2(GENE_W) : 1
) (
    input  logic [GENE_W-1:0] par_a,
    input  logic [GENE_W-1:0] par_b,
    input  logic [GENE_W-1:0] mask,
    input  logic [GENE_W-1:0] gene,
    input  logic [BIT_W-1:0]  bit_sel,
    input  logic              flip,
    output logic [GENE_W-1:0] crossed,
    output logic [GENE_W-1:0] mutated
);
    genvar k;
    generate
        for (k = 0; k < GENE_W; k++) begin : g_bit
            assign crossed[k] = mask[k] ? par_a[k] : par_b[k];
            assign mutated[k] = gene[k] ^ (flip && bit_sel == BIT_W'(k));
        end
    endgenerate
endmodule

// File: rtl/ga_engine.sv
module ga_engine
    import ga_pkg::*;
#(
    parameter int POP       = 10,
    parameter int GENE_W    = 16,
    parameter int FIT_W     = 16,
    parameter int MAX_GEN   = 30000,
    parameter int STALL_LIM = 10000,
    localparam int GEN_W    = $clog2(MAX_GEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       seed,
    input  logic [7:0]        mut_thresh,
    output logic              fit_req,
    output logic [GENE_W-1:0] fit_ind,
    input  logic              fit_ack,
    input  logic [FIT_W-1:0]  fit_val,
    output logic              done,
    output logic [GEN_W-1:0]  gen_count,
    output logic [FIT_W-1:0]  best_fit,
    output logic [GENE_W-1:0] best_ind
);
    localparam int IDX_W   = (POP > 1) ? $clog2(POP) : 1;
    localparam int TOT_W   = FIT_W + IDX_W;
    localparam int PROD_W  = TOT_W + 16;
    localparam int STALL_W = $clog2(STALL_LIM + 1);
    localparam int BIT_W   = (GENE_W > 1) ? $clog2(GENE_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(POP - 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(GENE_W - 1);

    ga_state_e state, nstate;

    logic [31:0]        rnd;
    logic [IDX_W-1:0]   idx, cidx, walk_j, rd_idx;
    logic [BIT_W-1:0]   bitn;
    logic [GEN_W-1:0]   gen;
    logic [STALL_W-1:0] stall;
    logic [TOT_W-1:0]   tot, acc, target;
    logic [GENE_W-1:0]  pa, pb, child;
    logic               have_best, improved;

    logic [GENE_W-1:0]  rd_gene, crossed, mutated;
    logic [FIT_W-1:0]   rd_fit;
    logic [GEN_W-1:0]   gen_nx;
    logic [STALL_W-1:0] stall_nx;
    logic               stop_now, hit, fit_win, mut_flip, go;
    logic [TOT_W-1:0]   walk_sum;
    logic [PROD_W-1:0]  prod;

    logic               lfsr_load, seed_we, fit_we, nxt_we, commit;
    logic [IDX_W-1:0]   nxt_idx;
    logic [GENE_W-1:0]  nxt_gene;

    ga_lfsr u_lfsr (
        .clk  (clk),
        .rst_n(rst_n),
        .load (lfsr_load),
        .seed (seed),
        .q    (rnd)
    );

    ga_pop_store #(.POP(POP), .GENE_W(GENE_W), .FIT_W(FIT_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .seed_we  (seed_we),
        .seed_idx (idx),
        .seed_gene(rnd[GENE_W-1:0]),
        .fit_we   (fit_we),
        .fit_idx  (idx),
        .fit_in   (fit_val),
        .nxt_we   (nxt_we),
        .nxt_idx  (nxt_idx),
        .nxt_gene (nxt_gene),
        .commit   (commit),
        .rd_idx   (rd_idx),
        .rd_gene  (rd_gene),
        .rd_fit   (rd_fit)
    );

    ga_gene_ops #(.GENE_W(GENE_W)) u_ops (
        .par_a  (pa),
        .par_b  (pb),
        .mask   (rnd[GENE_W-1:0]),
        .gene   (child),
        .bit_sel(bitn),
        .flip   (mut_flip),
        .crossed(crossed),
        .mutated(mutated)
    );

    // shared decisions
    always_comb begin
        go       = start && (state == ST_IDLE || state == ST_DONE);
        gen_nx   = gen + GEN_W'(1);
        stall_nx = improved ? '0 : stall + STALL_W'(1);
        stop_now = (gen_nx == GEN_W'(MAX_GEN)) || (stall_nx == STALL_W'(STALL_LIM));
        walk_sum = acc + TOT_W'(rd_fit);
        hit      = (walk_sum > target) || (walk_j == LAST_IDX) || (tot == '0);
        fit_win  = !have_best || (fit_val > best_fit);
        mut_flip = rnd[7:0] < mut_thresh;
        prod     = PROD_W'(rnd[31:16]) * PROD_W'(tot);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // transitions
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:   if (go) nstate = ST_SEED;
            ST_SEED:   if (idx == LAST_IDX) nstate = ST_EVAL;
            ST_EVAL:   if (fit_ack && idx == LAST_IDX) nstate = ST_JUDGE;
            ST_JUDGE:  nstate = stop_now ? ST_DONE : ST_PICK_A;
            ST_PICK_A: nstate = ST_WALK_A;
            ST_WALK_A: if (hit) nstate = ST_PICK_B;
            ST_PICK_B: nstate = ST_WALK_B;
            ST_WALK_B: if (hit) nstate = ST_CROSS;
            ST_CROSS:  nstate = ST_MUTATE;
            ST_MUTATE: if (bitn == LAST_BIT) nstate = ST_STORE;
            ST_STORE:  nstate = (cidx == LAST_IDX) ? ST_COMMIT : ST_PICK_A;
            ST_COMMIT: nstate = ST_EVAL;
            ST_DONE:   if (go) nstate = ST_SEED;
            default:   nstate = ST_IDLE;
        endcase
    end

    // outputs and store strobes
    always_comb begin
        fit_req   = (state == ST_EVAL);
        done      = (state == ST_DONE);
        fit_ind   = rd_gene;
        lfsr_load = go;
        seed_we   = (state == ST_SEED);
        fit_we    = (state == ST_EVAL) && fit_ack;
        nxt_we    = ((state == ST_JUDGE) && !stop_now) || (state == ST_STORE);
        nxt_idx   = (state == ST_JUDGE) ? '0 : cidx;
        nxt_gene  = (state == ST_JUDGE) ? best_ind : child;
        commit    = (state == ST_COMMIT);
        rd_idx    = (state == ST_WALK_A || state == ST_WALK_B) ? walk_j : idx;
        gen_count = gen;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0; cidx <= '0; walk_j <= '0; bitn <= '0;
            gen <= '0; stall <= '0; tot <= '0; acc <= '0; target <= '0;
            pa <= '0; pb <= '0; child <= '0;
            best_fit <= '0; best_ind <= '0; have_best <= 1'b0; improved <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE, ST_DONE: begin
                    if (go) begin
                        idx <= '0; gen <= '0; stall <= '0;
                        best_fit <= '0; best_ind <= '0; have_best <= 1'b0;
                    end
                end
                ST_SEED: begin
                    if (idx == LAST_IDX) begin
                        idx <= '0; tot <= '0; improved <= 1'b0;
                    end else begin
                        idx <= idx + IDX_W'(1);
                    end
                end
                ST_EVAL: begin
                    if (fit_ack) begin
                        tot <= tot + TOT_W'(fit_val);
                        if (fit_win) begin
                            best_fit  <= fit_val;
                            best_ind  <= rd_gene;
                            have_best <= 1'b1;
                            improved  <= 1'b1;
                        end
                        idx <= (idx == LAST_IDX) ? '0 : idx + IDX_W'(1);
                    end
                end
                ST_JUDGE: begin
                    gen   <= gen_nx;
                    stall <= stall_nx;
                    cidx  <= IDX_W'(1);
                end
                ST_PICK_A, ST_PICK_B: begin
                    target <= prod[PROD_W-1:16];
                    acc    <= '0;
                    walk_j <= '0;
                end
                ST_WALK_A, ST_WALK_B: begin
                    if (hit) begin
                        if (state == ST_WALK_A) pa <= rd_gene;
                        else                    pb <= rd_gene;
                    end else begin
                        acc    <= walk_sum;
                        walk_j <= walk_j + IDX_W'(1);
                    end
                end
                ST_CROSS: begin
                    child <= crossed;
                    bitn  <= '0;
                end
                ST_MUTATE: begin
                    child <= mutated;
                    bitn  <= bitn + BIT_W'(1);
                end
                ST_STORE: begin
                    if (cidx != LAST_IDX) cidx <= cidx + IDX_W'(1);
                end
                ST_COMMIT: begin
                    idx <= '0; tot <= '0; improved <= 1'b0;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ga_engine_chk.sv
module ga_engine_chk #(
    parameter int GENE_W  = 16,
    parameter int FIT_W   = 16,
    parameter int MAX_GEN = 30000,
    localparam int GEN_W  = $clog2(MAX_GEN + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              fit_req,
    input logic [GENE_W-1:0] fit_ind,
    input logic              fit_ack,
    input logic [FIT_W-1:0]  fit_val,
    input logic              done,
    input logic [GEN_W-1:0]  gen_count,
    input logic [FIT_W-1:0]  best_fit
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fit_req && !fit_ack) |=> (fit_req && $stable(fit_ind))); // R3
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !fit_req); // R11
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done); // R11
    AST_GEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        gen_count <= GEN_W'(MAX_GEN)); // R9
    AST_BEST_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (best_fit >= $past(best_fit))); // R4
    AST_BEST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (fit_req && fit_ack) |=> (best_fit >= $past(fit_val))); // R4
endmodule

bind ga_engine ga_engine_chk #(
    .GENE_W (GENE_W),
    .FIT_W  (FIT_W),
    .MAX_GEN(MAX_GEN)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .fit_req  (fit_req),
    .fit_ind  (fit_ind),
    .fit_ack  (fit_ack),
    .fit_val  (fit_val),
    .done     (done),
    .gen_count(gen_count),
    .best_fit (best_fit)
);

// File: tb/ga_engine_test.sv
module ga_engine_test;
    localparam int POP = 10, GW = 16, FW = 16, MAXG = 12, STL = 4;
    localparam int GNW = $clog2(MAXG + 1);
    localparam int WD_LIMIT = 150000;

    localparam logic [2:0] M_ZERO = 3'd0, M_SINGLE = 3'd1, M_PAIR = 3'd2,
                           M_MUT = 3'd3, M_RAMP = 3'd4, M_POPC = 3'd5;

    typedef struct packed {
        logic [2:0]  mode;
        logic [31:0] seed;
        logic [7:0]  thr;
    } scen_t;

    localparam scen_t SCEN [6] = '{
        '{M_ZERO,   32'h0000_1234, 8'd0},
        '{M_SINGLE, 32'hBEEF_0001, 8'd0},
        '{M_PAIR,   32'h1357_2468, 8'd0},
        '{M_MUT,    32'h0F0F_1234, 8'd255},
        '{M_RAMP,   32'hDEAD_BEEF, 8'd40},
        '{M_POPC,   32'h0000_0000, 8'd8}
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, fit_ack = 1'b0;
    logic [31:0] seed = '0;
    logic [7:0]  mut_thresh = '0;
    logic [FW-1:0] fit_val = '0;
    logic fit_req, done;
    logic [GW-1:0] fit_ind, best_ind;
    logic [GNW-1:0] gen_count;
    logic [FW-1:0] best_fit;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit wd_hit = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ga_engine #(.POP(POP), .GENE_W(GW), .FIT_W(FW), .MAX_GEN(MAXG), .STALL_LIM(STL)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .seed(seed), .mut_thresh(mut_thresh),
        .fit_req(fit_req), .fit_ind(fit_ind), .fit_ack(fit_ack), .fit_val(fit_val),
        .done(done), .gen_count(gen_count), .best_fit(best_fit), .best_ind(best_ind)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [FW-1:0] fit_of(input logic [2:0] m, input int g, input int gi,
                                              input int req, input logic [GW-1:0] ind);
        case (m)
            M_SINGLE, M_MUT: return (g == 1 && gi == 3) ? FW'(5) : '0;
            M_PAIR:  return (g == 1 && gi == 3) ? FW'(5) : (g == 1 && gi == 6) ? FW'(7) : '0;
            M_RAMP:  return FW'(req + 1);
            M_POPC:  return FW'($countones(ind));
            default: return '0;
        endcase
    endfunction

    task automatic run_scen(input scen_t sc);
        logic [GW-1:0] g1 [POP];
        logic [GW-1:0] g2 [POP];
        logic [GW-1:0] mb_ind = '0;
        logic [FW-1:0] mb = '0;
        bit mhave = 0, mimp = 0, stopped = 0;
        int req = 0, mgen = 0, mstall = 0, exp_stop = 0, ndiff = 0, nsame = 0;
        seed = sc.seed;
        mut_thresh = sc.thr;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        forever begin
            @(negedge clk);
            fit_ack = 1'b0;
            if (done) break;
            if (cyc > WD_LIMIT) begin wd_hit = 1'b1; break; end
            if (fit_req) begin
                automatic int gi = req % POP;
                automatic int g = req / POP + 1;
                automatic logic [FW-1:0] f = fit_of(sc.mode, g, gi, req, fit_ind);
                if (g == 1) g1[gi] = fit_ind;
                if (g == 2) g2[gi] = fit_ind;
                if (gi == 0 && g >= 2)
                    check(fit_ind == mb_ind, "R5 elite in slot 0", 64'(fit_ind), 64'(mb_ind));
                if (!mhave || f > mb) begin mb = f; mb_ind = fit_ind; mhave = 1; mimp = 1; end
                fit_val = f;
                fit_ack = 1'b1;
                req++;
                if (gi == POP - 1) begin
                    mgen++;
                    mstall = mimp ? 0 : mstall + 1;
                    mimp = 0;
                    if (!stopped && (mgen == MAXG || mstall == STL)) begin
                        stopped = 1; exp_stop = mgen;
                    end
                end
            end
        end
        // R9 R10 R3 stop point and request count
        check(gen_count == GNW'(exp_stop), "R10/R9 gen_count at stop", 64'(gen_count), 64'(exp_stop));
        check(req == POP * exp_stop, "R3 requests per run", 64'(req), 64'(POP * exp_stop));
        check(best_fit == mb, "R4 best_fit", 64'(best_fit), 64'(mb));
        check(best_ind == mb_ind, "R4 best_ind", 64'(best_ind), 64'(mb_ind));
        case (sc.mode)
            M_ZERO: begin
                for (int i = 0; i < POP; i++) if (g2[i] != g1[0]) ndiff++;
                check(ndiff == 0, "R6 zero total picks slot 0", 64'(ndiff), 64'd0);
            end
            M_SINGLE: begin
                for (int i = 0; i < POP; i++) if (g2[i] != g1[3]) ndiff++;
                check(ndiff == 0, "R6 R8 only fit parent drawn, no mutation", 64'(ndiff), 64'd0);
            end
            M_PAIR: begin
                for (int i = 0; i < POP; i++)
                    if (((g2[i] ^ g1[3]) & ~(g1[3] ^ g1[6])) != '0) ndiff++;
                check(ndiff == 0, "R7 child bits from parents", 64'(ndiff), 64'd0);
                check(g2[0] == g1[6], "R5 elite of pair", 64'(g2[0]), 64'(g1[6]));
            end
            M_MUT: begin
                for (int i = 1; i < POP; i++) if (g2[i] != g1[3]) ndiff++;
                check(ndiff > 0, "R8 mutation at high threshold", 64'(ndiff), 64'd1);
                check(g2[0] == g1[3], "R8 elite untouched by mutation", 64'(g2[0]), 64'(g1[3]));
            end
            M_RAMP: check(gen_count == GNW'(MAXG), "R9 generation limit", 64'(gen_count), 64'(MAXG));
            default: begin
                for (int i = 1; i < POP; i++) if (g1[i] == g1[0]) nsame++;
                check(nsame < POP - 1, "R2 zero seed gives varied population", 64'(nsame), 64'd0);
                check($countones(best_ind) == int'(best_fit), "R4 best matches its fitness",
                      64'($countones(best_ind)), 64'(best_fit));
            end
        endcase
        repeat (5) @(negedge clk);
        check(done && !fit_req, "R11 done holds, no requests", {62'd0, done, fit_req}, 64'd2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!done && !fit_req && gen_count == '0 && best_fit == '0, "R1 in reset",
              {done, fit_req, 62'(best_fit)}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!done && !fit_req && gen_count == '0, "R1 after release", {done, fit_req, 62'(gen_count)}, 64'd0);
        foreach (SCEN[s]) run_scen(SCEN[s]);
        // directed: reset in mid run
        seed = 32'h5555_0001;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (20) @(negedge clk);
        check(fit_req, "R3 request pending without ack", 64'(fit_req), 64'd1);
        rst_n = 1'b0;
        @(negedge clk);
        check(!done && !fit_req && gen_count == '0 && best_fit == '0, "R1 mid-run reset",
              {done, fit_req, 62'(best_fit)}, 64'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!done && !fit_req, "R1 idle after reset", {62'd0, done, fit_req}, 64'd0);
        if (wd_hit) check(1'b0, "watchdog", 64'(cyc), 64'(WD_LIMIT));
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule